// File: doc/BRIEF.md
# Bus-Start Watchdog Timer

This block is a watchdog whose keep-alive is not a dedicated pin. The host keeps it quiet by putting a START pattern on a shared two-wire serial bus, meaning the data line falls while the clock line stays high. Both bus lines are sampled through two-flop synchronizers. The pattern is then detected in the system clock domain. Each detection restarts the count.

A two-bit period select chooses one of three timeout lengths, or turns the timer off. The lengths are 1400, 600 and 200 milliseconds, expressed in timebase ticks. The tick is derived from the system clock by a parameterised divider. The select lives in a register that stands in for nonvolatile storage, and it is cleared only by the block's own reset.

A write to the select is refused while the write-protect input and the lock-enable bit are both high. An accepted write that changes the value restarts the count. When a period elapses without a restart, the block emits a one-cycle timeout request to the reset generator. While that generator holds its reset active, the count stays at zero.

Top module: `bswd_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `timeout` is 0 and `period_sel` reads 2'b00.
- R2: An SDA fall that happens while SCL is high restarts the count. `timeout` then pulses exactly 3 + L·TICK_DIV clock edges after the edge at which SDA was driven low. L is the tick count of the selected period.
- R3: The following leave the count running undisturbed: an SDA fall while SCL is low, an SCL rise while SDA is low, and an SDA rise while SCL is high.
- R4: `timeout` is high for exactly one cycle. With no activity, it repeats every L·TICK_DIV cycles.
- R5: The select codes map to tick counts as follows: 2'b00 gives 1400·TICKS_PER_MS ticks, 2'b01 gives 600·TICKS_PER_MS, and 2'b10 gives 200·TICKS_PER_MS.
- R6: With select 2'b11, the timer is off and `timeout` never rises.
- R7: A write is refused when `wp_in` and `lock_en` are both 1. A refused write leaves `period_sel` and the running count unchanged. If only one of the two is 1, the write is accepted.
- R8: An accepted write shows on `period_sel` one cycle later. If the value changed, the count restarts, and `timeout` comes L·TICK_DIV cycles after the edge following the write edge.
- R9: While `reset_active` is high, `timeout` stays 0 and the count is held at zero. Counting starts afresh from the last edge at which it was high.
- R10: When a restart lands on the same edge as an expiry, the restart wins. No pulse is produced, and the next pulse comes a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also the power-up load of the select |
| sda_in | input | 1 | Raw serial data line, asynchronous |
| scl_in | input | 1 | Raw serial clock line, asynchronous |
| reset_active | input | 1 | High while the reset generator drives system reset |
| wp_in | input | 1 | Write-protect input |
| lock_en | input | 1 | Lock-enable bit; together with `wp_in` it freezes the select |
| sel_wr_en | input | 1 | Write strobe for the period select |
| sel_wr_data | input | 2 | New period select value |
| period_sel | output | 2 | Current period select |
| timeout | output | 1 | One-cycle timeout request to the reset generator |

## Verification
A restart and an expiry can fall on the same clock edge. This is provoked by driving SDA low exactly three edges before the edge that would end the current period. The case is judged by the scoreboard seeing no pulse at that edge and one pulse exactly a full period after the restart.

A change to the period select is also made while a count is under way. That check confirms the new period starts from zero instead of mixing with the old one.

// File: rtl/bswd_pkg.sv
package bswd_pkg;

    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    typedef struct packed {
        logic sda;
        logic scl;
    } wd_bus_t;

    localparam int unsigned LONG_MS  = 1400;
    localparam int unsigned MID_MS   = 600;
    localparam int unsigned SHORT_MS = 200;

    // Ticks of the timebase for a given selection; zero when the timer is off.
    function automatic int unsigned wd_limit(input wd_sel_e s, input int unsigned tpm);
        case (s)
            WD_LONG:  return LONG_MS * tpm;
            WD_MID:   return MID_MS * tpm;
            WD_SHORT: return SHORT_MS * tpm;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/bswd_sync.sv
module bswd_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Idle bus level is high, so the chain resets to ones.
    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bswd_start_det.sv
module bswd_start_det
    import bswd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wd_bus_t bus,
    output logic    start
);
    wd_bus_t prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '1;
        end else begin
            prev <= bus;
        end
    end

    // Data falls while the clock line was and still is high.
    assign start = prev.sda & ~bus.sda & prev.scl & bus.scl;
endmodule

// File: rtl/bswd_sel_reg.sv
module bswd_sel_reg
    import bswd_pkg::*;
#(
    parameter logic [1:0] SEL_INIT = 2'b00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    input  logic       wp,
    input  logic       lock,
    output wd_sel_e    sel,
    output logic       chg
);
    logic accept;

    assign accept = wr_en & ~(wp & lock);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= wd_sel_e'(SEL_INIT);
            chg <= 1'b0;
        end else begin
            chg <= accept && (wr_data != sel);
            if (accept) begin
                sel <= wd_sel_e'(wr_data);
            end
        end
    end
endmodule

// File: rtl/bswd_timer.sv
module bswd_timer
    import bswd_pkg::*;
#(
    parameter int unsigned TICK_DIV     = 100000,
    parameter int unsigned TICKS_PER_MS = 1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  wd_sel_e sel,
    output logic    timeout
);
    localparam int unsigned MAX_TICKS = LONG_MS * TICKS_PER_MS;
    localparam int CW = $clog2(MAX_TICKS + 1);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0] presc;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic          tick_end;
    logic          hold;

    assign limit    = CW'(wd_limit(sel, TICKS_PER_MS));
    assign tick_end = (presc == PW'(TICK_DIV - 1));
    assign hold     = rst | clear | (sel == WD_OFF);

    always_ff @(posedge clk) begin
        if (hold) begin
            presc   <= '0;
            cnt     <= '0;
            timeout <= 1'b0;
        end else begin
            timeout <= 1'b0;
            if (tick_end) begin
                presc <= '0;
                if (cnt == limit - CW'(1)) begin
                    cnt     <= '0;
                    timeout <= 1'b1;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end else begin
                presc <= presc + PW'(1);
            end
        end
    end
endmodule

// File: rtl/bswd_top.sv
module bswd_top
    import bswd_pkg::*;
#(
    parameter int unsigned TICK_DIV     = 100000,
    parameter int unsigned TICKS_PER_MS = 1,
    parameter logic [1:0]  SEL_INIT     = 2'b00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sda_in,
    input  logic       scl_in,
    input  logic       reset_active,
    input  logic       wp_in,
    input  logic       lock_en,
    input  logic       sel_wr_en,
    input  logic [1:0] sel_wr_data,
    output logic [1:0] period_sel,
    output logic       timeout
);
    wd_bus_t bus_s;
    wd_sel_e sel;
    logic    sel_chg;
    logic    start_evt;
    logic    restart;

    bswd_sync #(.W(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sda_in, scl_in}),
        .q   (bus_s)
    );

    bswd_start_det u_det (
        .clk   (clk),
        .rst   (rst),
        .bus   (bus_s),
        .start (start_evt)
    );

    bswd_sel_reg #(.SEL_INIT(SEL_INIT)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sel_wr_en),
        .wr_data (sel_wr_data),
        .wp      (wp_in),
        .lock    (lock_en),
        .sel     (sel),
        .chg     (sel_chg)
    );

    assign restart = start_evt | sel_chg | reset_active;

    bswd_timer #(.TICK_DIV(TICK_DIV), .TICKS_PER_MS(TICKS_PER_MS)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clear   (restart),
        .sel     (sel),
        .timeout (timeout)
    );

    assign period_sel = sel;
endmodule

// File: rtl/bswd_chk.sv
module bswd_chk (
    input logic       clk,
    input logic       rst,
    input logic       reset_active,
    input logic       wp_in,
    input logic       lock_en,
    input logic       sel_wr_en,
    input logic [1:0] sel_wr_data,
    input logic [1:0] period_sel,
    input logic       timeout,
    input logic       start_evt
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!timeout && period_sel == 2'b00));

    assert_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout);

    assert_off_R6: assert property (@(posedge clk) disable iff (rst)
        (period_sel == 2'b11) |=> !timeout);

    assert_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (sel_wr_en && wp_in && lock_en) |=> $stable(period_sel));

    assert_load_R8: assert property (@(posedge clk) disable iff (rst)
        (sel_wr_en && !(wp_in && lock_en)) |=> (period_sel == $past(sel_wr_data)));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        reset_active |=> !timeout);

    assert_restart_wins_R10: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> !timeout);
endmodule

bind bswd_top bswd_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .reset_active (reset_active),
    .wp_in        (wp_in),
    .lock_en      (lock_en),
    .sel_wr_en    (sel_wr_en),
    .sel_wr_data  (sel_wr_data),
    .period_sel   (period_sel),
    .timeout      (timeout),
    .start_evt    (start_evt)
);

// File: tb/bswd_top_tb.sv
module bswd_top_tb;
    localparam int TD  = 3;
    localparam int TPM = 1;
    localparam int L00 = 1400 * TPM * TD;
    localparam int L01 = 600 * TPM * TD;
    localparam int L10 = 200 * TPM * TD;

    logic       clk = 0;
    logic       rst = 1;
    logic       sda = 1;
    logic       scl = 1;
    logic       reset_active = 1;
    logic       wp = 0;
    logic       lock = 0;
    logic       wr_en = 0;
    logic [1:0] wr_data = 2'b00;
    logic [1:0] period_sel;
    logic       timeout;

    int    cyc = 0;
    int    ntests = 0;
    int    nfail = 0;
    int    unexp = 0;
    int    q[$];
    string qtag[$];

    bswd_top #(.TICK_DIV(TD), .TICKS_PER_MS(TPM), .SEL_INIT(2'b00)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .sda_in       (sda),
        .scl_in       (scl),
        .reset_active (reset_active),
        .wp_in        (wp),
        .lock_en      (lock),
        .sel_wr_en    (wr_en),
        .sel_wr_data  (wr_data),
        .period_sel   (period_sel),
        .timeout      (timeout)
    );

    initial forever #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every pulse must match the head of the expectation queue.
    always @(negedge clk) begin
        if (!rst && timeout) begin
            if (q.size() == 0) begin
                ntests++;
                nfail++;
                unexp++;
                $display("FAIL R4 unexpected timeout at edge %0d (actual pulse, expected none)", cyc);
            end else begin
                int    e;
                string t;
                e = q.pop_front();
                t = qtag.pop_front();
                ntests++;
                if (e != cyc) begin
                    nfail++;
                    $display("FAIL %s timeout edge actual %0d expected %0d", t, cyc, e);
                end
            end
        end
    end

    task automatic check_val(input string req, input int act, input int exp);
        ntests++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int e, input string t);
        q.push_back(e);
        qtag.push_back(t);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic write_sel(input logic [1:0] d);
        wr_data = d;
        wr_en   = 1;
        @(negedge clk);
        wr_en   = 0;
        step(3);
    endtask

    task automatic release_run(output int k);
        reset_active = 0;
        k = cyc;
    endtask

    task automatic quiet_on(input string req);
        reset_active = 1;
        step(2);
        check_val(req, q.size(), 0);
    endtask

    task automatic bus_start(input int len, input string t, output int k);
        sda = 0;
        k = cyc;
        push(k + 3 + len, t);
        step(4);
        sda = 1;
        step(1);
    endtask

    initial begin
        int k, k2, kw, u0;
        step(5);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        check_val("R1", timeout, 0);
        check_val("R1", period_sel, 0);

        // R2 / R5: restart by START, long period
        release_run(k);
        step(500);
        bus_start(L00, "R2", k2);
        wait_until(k2 + 3 + L00 + 2);
        quiet_on("R2");
        check_val("R5", period_sel, 0);

        // R3 / R4: short period, events that are not START, free repeat
        write_sel(2'b10);
        release_run(k);
        push(k + L10, "R3");
        push(k + 2 * L10, "R4");
        step(100);
        scl = 0; step(3);
        sda = 0; step(3);
        scl = 1; step(3);
        sda = 1; step(3);
        wait_until(k + 2 * L10 + 2);
        quiet_on("R4");

        // R5: middle period
        write_sel(2'b01);
        check_val("R5", period_sel, 1);
        release_run(k);
        push(k + L01, "R5");
        wait_until(k + L01 + 2);
        quiet_on("R5");

        // R6: timer off
        write_sel(2'b11);
        check_val("R6", period_sel, 3);
        u0 = unexp;
        release_run(k);
        step(L00 + 100);
        check_val("R6", unexp - u0, 0);
        check_val("R6", timeout, 0);
        quiet_on("R6");

        // R8: changing the select mid-count restarts with the new period
        write_sel(2'b10);
        release_run(k);
        step(300);
        kw = cyc;
        push(kw + 2 + L01, "R8");
        write_sel(2'b01);
        check_val("R8", period_sel, 1);
        wait_until(kw + 2 + L01 + 2);
        quiet_on("R8");

        // R9: reset_active holds the count at zero
        release_run(k);
        step(1000);
        u0 = unexp;
        reset_active = 1;
        step(2000);
        check_val("R9", unexp - u0, 0);
        check_val("R9", timeout, 0);
        release_run(k2);
        push(k2 + L01, "R9");
        wait_until(k2 + L01 + 2);
        quiet_on("R9");

        // R7: lock gating
        write_sel(2'b10);
        check_val("R8", period_sel, 2);
        wp = 1; lock = 1;
        write_sel(2'b01);
        check_val("R7", period_sel, 2);
        wp = 1; lock = 0;
        write_sel(2'b00);
        check_val("R7", period_sel, 0);
        wp = 0; lock = 1;
        write_sel(2'b10);
        check_val("R7", period_sel, 2);
        release_run(k);
        push(k + L10, "R7");
        step(200);
        wp = 1; lock = 1;
        write_sel(2'b01);
        check_val("R7", period_sel, 2);
        wp = 0; lock = 0;
        wait_until(k + L10 + 2);
        quiet_on("R7");

        // R10: restart lands on the expiry edge
        release_run(k);
        wait_until(k + L10 - 3);
        bus_start(L10, "R10", k2);
        check_val("R10", k2 + 3, k + L10);
        wait_until(k2 + 3 + L10 + 2);
        quiet_on("R10");

        step(20);
        check_val("R4", q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        ntests++;
        nfail++;
        $display("FAIL watchdog expired (actual hung, expected finish)");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule